// File: doc/BRIEF.md
# Character Display Parallel Bus Master

This block runs single register transfers from a host to a character display controller over that controller's parallel bus. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. The user side raises a request with a register select, a direction and a byte. When the transfer is over, the block returns a one-cycle completion pulse, and for reads it also returns the byte that was read. The block never drives a tri-state pin itself. It provides separate outgoing data, a data output-enable and incoming data, and the pad ring combines these into the bidirectional bus.

Every bus interval is set in nanoseconds and turned into clock cycles from the clock period parameter. These intervals are the control setup before the strobe rises, the strobe high width, the control and data hold after the strobe falls, the minimum spacing from one strobe rise to the next, and the guard gap after the controller reports idle. A narrow-bus input, sampled when a request is accepted, selects four-line operation. In that mode only the upper four data lines carry information, and each byte needs two complete strobes.

A request can ask for a busy check first. The block then reads the controller's status register repeatedly until the busy bit reads low, waits the guard interval, and then performs the requested transfer. If too many busy results arrive in a row, the block gives up and reports an error on the completion pulse.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset, `req_ready` is 1 while `bus_strobe`, `bus_doe` and `done` are 0. `req_ready` is high only while the engine is idle. A request is taken only in a clock where `req_valid` and `req_ready` are both 1, and a `req_valid` raised while busy starts no extra transfer.
- R2: `bus_regsel` and `bus_read` stay unchanged for at least ceil(SETUP_NS/CLK_NS) cycles before `bus_strobe` rises. They also stay unchanged while the strobe is high and in the cycle after it falls.
- R3: Each strobe stays high for at least ceil(STROBE_NS/CLK_NS) cycles. Two consecutive strobe rises are at least ceil(PERIOD_NS/CLK_NS) cycles apart.
- R4: `bus_doe` is 1 only during write strobes (`bus_read`=0) and 0 during reads and idle. During a write the byte on `bus_dout` does not change from strobe rise until after the strobe falls.
- R5: In wide mode (`nibble_mode`=0) a transfer uses one strobe. A read returns the value on `bus_din[7:0]` during the strobe.
- R6: In narrow mode (`nibble_mode`=1) a transfer uses two strobes, with the upper nibble first and the lower nibble second. Both nibbles travel on lines 7..4, and `bus_dout[3:0]` is 0. For a read, the first nibble becomes `rdata[7:4]` and the second becomes `rdata[3:0]`, and `bus_din[3:0]` is ignored.
- R7: When `req_poll`=1, status reads (`bus_regsel`=0, `bus_read`=1) come before the transfer and repeat while the busy flag is 1. The busy flag is `bus_din[7]` of the status byte. In narrow mode it is taken from the first nibble only.
- R8: After a status read whose busy flag is 0, the first strobe of the transfer rises at least GUARD_NS/CLK_NS (rounded up) plus the setup count cycles after that status strobe fell.
- R9: After POLL_MAX status reads in a row that all report busy, the block pulses `done` with `timeout_err`=1 and issues no transfer strobe.
- R10: `done` is a one-cycle pulse. `timeout_err` is 0 on a completion that did not time out, and `rdata` is valid together with `done` after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_regsel | input | 1 | Register select to place on the bus |
| req_read | input | 1 | 1 = read transfer, 0 = write transfer |
| req_wdata | input | 8 | Byte to write |
| req_poll | input | 1 | Wait for controller idle before the transfer |
| nibble_mode | input | 1 | 1 = four-line bus, two strobes per byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with done |
| timeout_err | output | 1 | Busy never cleared, valid with done |
| bus_regsel | output | 1 | Register select line |
| bus_read | output | 1 | Read/write line, 1 = read |
| bus_strobe | output | 1 | Enable strobe |
| bus_dout | output | 8 | Outgoing data lines |
| bus_doe | output | 1 | Output enable for the data lines |
| bus_din | input | 8 | Incoming data lines |

## Verification
A state machine that leaves a phase early shows up on the bus within the next strobe. The strobe width, the setup count before a rise or the spacing between rises comes up short by at least one cycle, and this is visible at that same rise or fall. A nibble counter that is out of step changes the number of strobes and swaps the lane order of a byte, so it is exposed when that transfer completes. A wrong busy flag source or a wrong watchdog count either spins until the timeout or skips the guard gap. The first case shows up as an unexpected error pulse. The second shows up as a short gap between the last status strobe and the transfer strobe.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD,
    ST_GUARD
  } bus_state_t;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_interval_timer.sv
module lcd_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/lcd_poll_watchdog.sv
module lcd_poll_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                  cnt <= '0;
    else if (bump && cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // The next busy result is the LIMIT-th one in a row.
  assign last = (cnt >= W'(LIMIT - 1));

endmodule

// File: rtl/lcd_lane_map.sv
module lcd_lane_map
  import lcd_bus_pkg::*;
(
  input  logic              narrow,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_nib,
  output logic [BYTE_W-1:0] tx_lanes,
  input  logic [BYTE_W-1:0] cap_old,
  input  logic [BYTE_W-1:0] din,
  input  logic              rx_nib,
  output logic [BYTE_W-1:0] cap_new
);

  localparam int H = BYTE_W / 2;

  always_comb begin
    if (narrow) begin
      tx_lanes = {(tx_nib ? tx_byte[H-1:0] : tx_byte[BYTE_W-1:H]), {H{1'b0}}};
      cap_new  = rx_nib ? {cap_old[BYTE_W-1:H], din[BYTE_W-1:H]}
                        : {din[BYTE_W-1:H], cap_old[H-1:0]};
    end else begin
      tx_lanes = tx_byte;
      cap_new  = din;
    end
  end

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int CLK_NS    = 8,
  parameter int SETUP_NS  = 100,
  parameter int STROBE_NS = 300,
  parameter int HOLD_NS   = 10,
  parameter int PERIOD_NS = 500,
  parameter int GUARD_NS  = 1000,
  parameter int POLL_MAX  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_regsel,
  input  logic              req_read,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              req_poll,
  input  logic              nibble_mode,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              timeout_err,
  output logic              bus_regsel,
  output logic              bus_read,
  output logic              bus_strobe,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [BYTE_W-1:0] bus_din
);

  localparam int SU_CYC    = ns_to_cycles(SETUP_NS, CLK_NS);
  localparam int PW_CYC    = ns_to_cycles(STROBE_NS, CLK_NS);
  localparam int HOLD_MIN  = ns_to_cycles(HOLD_NS, CLK_NS);
  localparam int CYC_CYC   = ns_to_cycles(PERIOD_NS, CLK_NS);
  localparam int LOW_CYC   = imax(HOLD_MIN, CYC_CYC - PW_CYC - SU_CYC);
  localparam int GUARD_CYC = ns_to_cycles(GUARD_NS, CLK_NS);
  localparam int TMAX      = imax(imax(SU_CYC, PW_CYC), imax(LOW_CYC, GUARD_CYC));
  localparam int TW        = $clog2(TMAX + 1);

  bus_state_t state, state_n;

  logic              cur_rs, cur_rd, cur_poll, cur_narrow, nib;
  logic [BYTE_W-1:0] cur_wd, cap;
  logic              accept;
  logic              src_rs, src_rd, src_narrow;
  logic [BYTE_W-1:0] src_wd;
  logic              tm_load, tm_exp;
  logic [TW-1:0]     tm_val;
  logic              wd_bump, wd_last;
  logic              go_setup, nib_n, poll_n, finish, fail_n, do_cap;
  logic              drv_rs, drv_rd, drv_oe;
  logic [BYTE_W-1:0] tx_lanes, cap_new;

  assign accept = req_valid && req_ready;

  // Values for the next strobe: request ports while idle, latched copy after.
  always_comb begin
    if (state == ST_IDLE) begin
      src_rs = req_regsel; src_rd = req_read; src_wd = req_wdata; src_narrow = nibble_mode;
    end else begin
      src_rs = cur_rs;     src_rd = cur_rd;   src_wd = cur_wd;    src_narrow = cur_narrow;
    end
  end

  lcd_interval_timer #(.W(TW)) i_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
  );

  lcd_poll_watchdog #(.LIMIT(POLL_MAX)) i_wdog (
    .clk(clk), .rst(rst), .clear(accept), .bump(wd_bump), .last(wd_last)
  );

  lcd_lane_map i_lanes (
    .narrow  (src_narrow),
    .tx_byte (src_wd),
    .tx_nib  (nib_n),
    .tx_lanes(tx_lanes),
    .cap_old (cap),
    .din     (bus_din),
    .rx_nib  (nib),
    .cap_new (cap_new)
  );

  always_comb begin
    state_n  = state;
    tm_load  = 1'b0;
    tm_val   = '0;
    go_setup = 1'b0;
    nib_n    = nib;
    poll_n   = cur_poll;
    finish   = 1'b0;
    fail_n   = 1'b0;
    do_cap   = 1'b0;
    wd_bump  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          go_setup = 1'b1;
          nib_n    = 1'b0;
          poll_n   = req_poll;
        end
      end
      ST_SETUP: begin
        if (tm_exp) begin
          state_n = ST_HIGH;
          tm_load = 1'b1;
          tm_val  = TW'(PW_CYC - 1);
        end
      end
      ST_HIGH: begin
        if (tm_exp) begin
          state_n = ST_HOLD;
          tm_load = 1'b1;
          tm_val  = TW'(LOW_CYC - 1);
          do_cap  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tm_exp) begin
          if (cur_narrow && !nib) begin
            go_setup = 1'b1;
            nib_n    = 1'b1;
          end else if (cur_poll) begin
            if (cap[BYTE_W-1]) begin
              if (wd_last) begin
                state_n = ST_IDLE;
                finish  = 1'b1;
                fail_n  = 1'b1;
              end else begin
                go_setup = 1'b1;
                nib_n    = 1'b0;
                wd_bump  = 1'b1;
              end
            end else begin
              state_n = ST_GUARD;
              tm_load = 1'b1;
              tm_val  = TW'(GUARD_CYC - 1);
              poll_n  = 1'b0;
            end
          end else begin
            state_n = ST_IDLE;
            finish  = 1'b1;
          end
        end
      end
      ST_GUARD: begin
        if (tm_exp) begin
          go_setup = 1'b1;
          nib_n    = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (go_setup) begin
      state_n = ST_SETUP;
      tm_load = 1'b1;
      tm_val  = TW'(SU_CYC - 1);
    end
  end

  always_comb begin
    drv_rs = poll_n ? 1'b0 : src_rs;
    drv_rd = poll_n ? 1'b1 : src_rd;
    drv_oe = !poll_n && !src_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_rs      <= 1'b0;
      cur_rd      <= 1'b0;
      cur_wd      <= '0;
      cur_poll    <= 1'b0;
      cur_narrow  <= 1'b0;
      nib         <= 1'b0;
      cap         <= '0;
      bus_regsel  <= 1'b0;
      bus_read    <= 1'b0;
      bus_doe     <= 1'b0;
      bus_dout    <= '0;
      bus_strobe  <= 1'b0;
      req_ready   <= 1'b1;
      done        <= 1'b0;
      rdata       <= '0;
      timeout_err <= 1'b0;
    end else begin
      state    <= state_n;
      nib      <= nib_n;
      cur_poll <= poll_n;
      if (accept) begin
        cur_rs     <= req_regsel;
        cur_rd     <= req_read;
        cur_wd     <= req_wdata;
        cur_narrow <= nibble_mode;
      end
      if (do_cap) cap <= cap_new;
      if (go_setup) begin
        bus_regsel <= drv_rs;
        bus_read   <= drv_rd;
        bus_doe    <= drv_oe;
        bus_dout   <= drv_oe ? tx_lanes : '0;
      end else if (state_n == ST_IDLE || state_n == ST_GUARD) begin
        bus_doe  <= 1'b0;
        bus_dout <= '0;
      end
      bus_strobe <= (state_n == ST_HIGH);
      req_ready  <= (state_n == ST_IDLE);
      done       <= finish;
      if (finish) timeout_err <= fail_n;
      if (finish && !fail_n && cur_rd) rdata <= cap;
    end
  end

endmodule

// File: rtl/lcd_bus_master_chk.sv
module lcd_bus_master_chk #(
  parameter int SU_CYC  = 1,
  parameter int PW_CYC  = 1,
  parameter int GAP_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       done,
  input logic       bus_regsel,
  input logic       bus_read,
  input logic       bus_strobe,
  input logic [7:0] bus_dout,
  input logic       bus_doe
);

  logic [15:0] stab_cnt, hi_cnt, gap_cnt;
  logic        prev_rs, prev_rd, seen_rise, strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stab_cnt  <= '0;
      hi_cnt    <= '0;
      gap_cnt   <= '0;
      prev_rs   <= 1'b0;
      prev_rd   <= 1'b0;
      seen_rise <= 1'b0;
      strobe_q  <= 1'b0;
    end else begin
      prev_rs  <= bus_regsel;
      prev_rd  <= bus_read;
      strobe_q <= bus_strobe;
      if (bus_regsel != prev_rs || bus_read != prev_rd) stab_cnt <= '0;
      else if (stab_cnt != 16'hFFFF)                    stab_cnt <= stab_cnt + 1'b1;
      if (bus_strobe) hi_cnt <= hi_cnt + 1'b1;
      else            hi_cnt <= '0;
      if (bus_strobe && !strobe_q) begin
        gap_cnt   <= 16'd1;
        seen_rise <= 1'b1;
      end else if (gap_cnt != 16'hFFFF) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_strobe && !bus_doe));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  ctrl_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe || (strobe_q && !bus_strobe)) |-> ($stable(bus_regsel) && $stable(bus_read)));

  // R2
  ctrl_setup_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !strobe_q) |-> (int'(stab_cnt) >= SU_CYC - 1));

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && !bus_strobe) |-> (int'(hi_cnt) >= PW_CYC));

  // R3
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !strobe_q && seen_rise) |-> (int'(gap_cnt) >= GAP_CYC));

  // R4
  drive_dir_chk: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !bus_read);

  // R4
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_strobe || (strobe_q && !bus_strobe)) && bus_doe) |-> $stable(bus_dout));

endmodule

bind lcd_bus_master lcd_bus_master_chk #(
  .SU_CYC (SU_CYC),
  .PW_CYC (PW_CYC),
  .GAP_CYC(CYC_CYC)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .bus_regsel(bus_regsel),
  .bus_read  (bus_read),
  .bus_strobe(bus_strobe),
  .bus_dout  (bus_dout),
  .bus_doe   (bus_doe)
);

// File: tb/test_lcd_bus_master.sv
`timescale 1ns/1ps
module test_lcd_bus_master;

  localparam int CLK_NS   = 8;
  localparam int GUARD_NS = 400;
  localparam int POLL_MAX = 4;
  localparam int E_SU     = (100 + CLK_NS - 1) / CLK_NS;
  localparam int E_PW     = (300 + CLK_NS - 1) / CLK_NS;
  localparam int E_GAP    = (500 + CLK_NS - 1) / CLK_NS;
  localparam int E_GUARD  = (GUARD_NS + CLK_NS - 1) / CLK_NS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_regsel = 1'b0, req_read = 1'b0, req_poll = 1'b0;
  logic       nibble_mode = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       req_ready, done, timeout_err;
  logic [7:0] rdata;
  logic       bus_regsel, bus_read, bus_strobe, bus_doe;
  logic [7:0] bus_dout, bus_din;

  always #4 clk = ~clk;

  lcd_bus_master #(
    .CLK_NS(CLK_NS), .GUARD_NS(GUARD_NS), .POLL_MAX(POLL_MAX)
  ) i_lcd_bus_master (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_regsel(req_regsel), .req_read(req_read), .req_wdata(req_wdata),
    .req_poll(req_poll), .nibble_mode(nibble_mode),
    .done(done), .rdata(rdata), .timeout_err(timeout_err),
    .bus_regsel(bus_regsel), .bus_read(bus_read), .bus_strobe(bus_strobe),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  // Controller model
  int         busy_left = 0;
  logic       busy_forever = 1'b0;
  logic [6:0] ac_val = 7'h00;
  logic [7:0] rd_byte = 8'h00;
  logic       rnib = 1'b0;
  logic [7:0] sel_byte;

  always_comb begin
    if (!bus_regsel && bus_read) sel_byte = {(busy_forever || busy_left > 0), ac_val};
    else                         sel_byte = rd_byte;
    if (nibble_mode) bus_din = rnib ? {sel_byte[3:0], 4'hA} : {sel_byte[7:4], 4'h5};
    else             bus_din = sel_byte;
  end

  // Bus monitor, sampled on the falling clock edge
  int         n_rise = 0, min_hi = 0, min_setup = 0, min_gap = 0, guard_gap = 0;
  int         hi = 0, stab = 0, gap_cnt = 0, since_pfall = 0;
  logic       saw_pfall = 1'b0, e_prev = 1'b0;
  logic [1:0] prev_ctrl = 2'b00;
  logic       lg_rs[32], lg_rd[32], lg_oe[32];
  logic [7:0] lg_d[32], lg_fd[32];

  always @(negedge clk) begin
    if ({bus_regsel, bus_read} != prev_ctrl) stab = 0; else stab = stab + 1;
    prev_ctrl   = {bus_regsel, bus_read};
    gap_cnt     = gap_cnt + 1;
    since_pfall = since_pfall + 1;
    if (bus_strobe && !e_prev) begin
      if (n_rise < 32) begin
        lg_rs[n_rise] = bus_regsel; lg_rd[n_rise] = bus_read;
        lg_oe[n_rise] = bus_doe;    lg_d[n_rise]  = bus_dout;
      end
      if (stab < min_setup) min_setup = stab;
      if (n_rise > 0 && gap_cnt < min_gap) min_gap = gap_cnt;
      gap_cnt = 0;
      if (!(!bus_regsel && bus_read) && saw_pfall && guard_gap < 0) guard_gap = since_pfall;
      n_rise = n_rise + 1;
    end
    if (bus_strobe) hi = hi + 1;
    if (!bus_strobe && e_prev) begin
      if (hi < min_hi) min_hi = hi;
      hi = 0;
      if (n_rise > 0 && n_rise <= 32) lg_fd[n_rise-1] = bus_dout;
      if (!bus_regsel && bus_read) begin
        since_pfall = 0;
        saw_pfall   = 1'b1;
      end
      if (nibble_mode) begin
        if (rnib) begin
          rnib = 1'b0;
          if (busy_left > 0) busy_left = busy_left - 1;
        end else begin
          rnib = 1'b1;
        end
      end else if (busy_left > 0) begin
        busy_left = busy_left - 1;
      end
    end
    e_prev = bus_strobe;
  end

  int n_checks = 0, n_fail = 0;
  logic [7:0] got_rdata;
  logic       got_err, got_done, pulse_ok;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input bit rs, input bit rd, input bit poll, input bit narrow,
                          input logic [7:0] wd, input bit poke);
    n_rise = 0; min_hi = 1000000; min_setup = 1000000; min_gap = 1000000;
    guard_gap = -1; saw_pfall = 1'b0; rnib = 1'b0; hi = 0;
    got_done = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_regsel = rs; req_read = rd; req_poll = poll; nibble_mode = narrow; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
      req_wdata = 8'hE7; req_regsel = ~rs; req_valid = 1'b1;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        got_done = 1'b1; got_rdata = rdata; got_err = timeout_err;
        break;
      end
      @(negedge clk);
    end
    chk(got_done, "R10 done seen", got_done, 1);
    @(negedge clk);
    pulse_ok = !done;
    chk(pulse_ok, "R10 done single cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(bus_strobe == 1'b0, "R1 reset strobe", bus_strobe, 0);
    chk(bus_doe == 1'b0, "R1 reset doe", bus_doe, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic t_write_wide;
    run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b1);
    chk(n_rise == 1, "R1 R5 one strobe, busy request ignored", n_rise, 1);
    chk(lg_rs[0] == 1'b1 && lg_rd[0] == 1'b0, "R5 write ctrl", {lg_rs[0], lg_rd[0]}, 2);
    chk(lg_oe[0] == 1'b1, "R4 doe on write", lg_oe[0], 1);
    chk(lg_d[0] == 8'h5A, "R4 write data at rise", lg_d[0], 8'h5A);
    chk(lg_fd[0] == 8'h5A, "R4 write data at fall", lg_fd[0], 8'h5A);
    chk(min_setup >= E_SU, "R2 setup cycles", min_setup, E_SU);
    chk(min_hi >= E_PW, "R3 strobe width", min_hi, E_PW);
    chk(got_err == 1'b0, "R10 no error", got_err, 0);
    chk(bus_doe == 1'b0, "R4 doe off when idle", bus_doe, 0);
  endtask

  task automatic t_read_wide;
    rd_byte = 8'hC3;
    run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(n_rise == 1, "R5 one strobe read", n_rise, 1);
    chk(lg_oe[0] == 1'b0, "R4 doe off on read", lg_oe[0], 0);
    chk(got_rdata == 8'hC3, "R5 read data", got_rdata, 8'hC3);
    chk(min_hi >= E_PW, "R3 strobe width read", min_hi, E_PW);
  endtask

  task automatic t_write_narrow;
    run_xfer(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0);
    chk(n_rise == 2, "R6 two strobes", n_rise, 2);
    chk(lg_d[0] == 8'h30, "R6 upper nibble first", lg_d[0], 8'h30);
    chk(lg_d[1] == 8'hC0, "R6 lower nibble second", lg_d[1], 8'hC0);
    chk(lg_rs[1] == 1'b0 && lg_rd[1] == 1'b0, "R6 ctrl kept", {lg_rs[1], lg_rd[1]}, 0);
    chk(min_gap >= E_GAP, "R3 rise spacing", min_gap, E_GAP);
    chk(min_setup >= E_SU, "R2 setup narrow", min_setup, E_SU);
  endtask

  task automatic t_read_narrow;
    rd_byte = 8'h9E;
    run_xfer(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    chk(n_rise == 2, "R6 two read strobes", n_rise, 2);
    chk(got_rdata == 8'h9E, "R6 nibble assembly", got_rdata, 8'h9E);
    chk(lg_oe[0] == 1'b0 && lg_oe[1] == 1'b0, "R4 no drive on narrow read", {lg_oe[0], lg_oe[1]}, 0);
  endtask

  task automatic t_poll_wide;
    busy_left = 2; ac_val = 7'h15;
    run_xfer(1'b1, 1'b0, 1'b1, 1'b0, 8'h41, 1'b0);
    chk(n_rise == 4, "R7 three polls then write", n_rise, 4);
    for (int i = 0; i < 3; i++)
      chk(lg_rs[i] == 1'b0 && lg_rd[i] == 1'b1 && lg_oe[i] == 1'b0, "R7 status read ctrl",
          {lg_rs[i], lg_rd[i], lg_oe[i]}, 3'b010);
    chk(lg_rs[3] == 1'b1 && lg_oe[3] == 1'b1 && lg_d[3] == 8'h41, "R7 transfer after poll",
        lg_d[3], 8'h41);
    chk(guard_gap >= E_GUARD + E_SU, "R8 guard gap", guard_gap, E_GUARD + E_SU);
    chk(got_err == 1'b0, "R10 no error after poll", got_err, 0);
  endtask

  task automatic t_poll_narrow;
    busy_left = 1; ac_val = 7'h4F; rd_byte = 8'h7B;
    run_xfer(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    chk(n_rise == 6, "R7 narrow poll flag from first nibble", n_rise, 6);
    chk(got_err == 1'b0, "R7 narrow poll no timeout", got_err, 0);
    chk(got_rdata == 8'h7B, "R6 R7 read after poll", got_rdata, 8'h7B);
    chk(guard_gap >= E_GUARD + E_SU, "R8 guard gap narrow", guard_gap, E_GUARD + E_SU);
  endtask

  task automatic t_timeout;
    busy_forever = 1'b1;
    run_xfer(1'b1, 1'b0, 1'b1, 1'b0, 8'h66, 1'b0);
    chk(got_err == 1'b1, "R9 timeout flagged", got_err, 1);
    chk(n_rise == POLL_MAX, "R9 poll count", n_rise, POLL_MAX);
    for (int i = 0; i < POLL_MAX; i++)
      chk(lg_oe[i] == 1'b0 && lg_rd[i] == 1'b1, "R9 no transfer strobe", {lg_oe[i], lg_rd[i]}, 1);
    busy_forever = 1'b0;
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 8'h99, 1'b0);
    chk(got_err == 1'b0, "R10 error cleared on next completion", got_err, 0);
    chk(n_rise == 1 && lg_d[0] == 8'h99, "R10 recovery write", lg_d[0], 8'h99);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_write_wide;
    t_read_wide;
    t_write_narrow;
    t_read_narrow;
    t_poll_wide;
    t_poll_narrow;
    t_timeout;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule